// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matcher

This block picks which cells cross an N-by-N bufferless crossbar in one cell slot. Each input keeps one queue per output. The scheduler receives a bitmap with N×N bits. Bit `i*N+j` is set when input `i` holds a cell for output `j`. The block returns a set of input-output pairs with no conflicts. Each input receives at most one output, and each output at most one input.

A start pulse captures the bitmap. The block then runs a fixed number of iterations, one per clock cycle. Each iteration has a request phase, a grant phase and an accept phase, and works only on ports that are still free. Each output keeps a rotating grant pointer and each input keeps a rotating accept pointer. Both pointers move only when a grant is accepted in the first iteration. This keeps the pointers from locking into step with each other when load is even. When the last iteration ends, the result appears on `match_o` together with a one-cycle `valid_o` pulse. The result stays on `match_o` until the next run completes.

Top module: `rr_xbar_matcher`

## Requirements
- R1: After a synchronous active-low reset, `valid_o` is 0 and `match_o` is all zeros. Every grant and accept pointer is 0, so the first run favours the lowest-numbered ports.
- R2: The bitmap on `req_i` is captured on the clock edge where `start_i` is sampled high while idle. Later changes to `req_i` have no effect on that run.
- R3: `valid_o` is high for exactly one cycle. That cycle begins ITERS clock edges after the edge that accepted the start.
- R4: The result is a legal matching. Each row `i` of `match_o` (bits `i*N .. i*N+N-1`, bit `j` meaning output `j`) has at most one bit set. Each output column has at most one bit set. Every set bit corresponds to a captured request.
- R5: With ITERS equal to N, the matching is maximal. No captured request joins an unmatched input to an unmatched output.
- R6: In each iteration, every free output that sees requests from free inputs grants exactly one of them. It grants the first requester found by scanning upward, with wrap-around, from its grant pointer.
- R7: In each iteration, every free input that receives grants accepts exactly one of them. It accepts the first grant found by scanning upward, with wrap-around, from its accept pointer. The input and that output then become matched.
- R8: When a grant is accepted in the first iteration of a run, the output's grant pointer moves to one past the accepting input. The input's accept pointer moves to one past the accepted output, both modulo N. No other event changes a pointer.
- R9: A start pulse that arrives while a run is in progress is ignored. It does not change the result and does not cause an extra `valid_o` pulse.
- R10: A start that arrives in the cycle where `valid_o` is high is accepted and begins a new run.
- R11: `match_o` keeps its value from the end of one run until the end of the next run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins a run when the block is idle |
| req_i | input | N*N | Request bitmap; bit i*N+j means input i has a cell for output j |
| match_o | output | N*N | Result pairs, same layout as req_i |
| valid_o | output | 1 | One-cycle pulse when a new result is on match_o |

## Verification
Two events can land in the same cycle: the completion pulse of one run and the start of the next. The bench drives every new start in the cycle where `valid_o` is high. Each result is therefore produced by a run that began while the previous result was still being reported. The bench checks each result against a model that keeps its own copy of the pointers, checks it for legality and maximality, and checks that the completion pulse arrives on time. A second case places a start inside a run that is still busy and changes the bitmap at the same moment. The bench checks that the result, the pulse timing and the pointer history all match the first start alone.

// File: rtl/rrm_pkg.sv
// Shared helpers for the round-robin matcher.
// Assumes port indices lie in 0..n-1.
package rrm_pkg;
    // Returns the port index one past idx, wrapping at n.
    function automatic int next_port(input int idx, input int n);
        return (idx >= n - 1) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/rr_pick.sv
// Round-robin picker: scans the request vector upward from ptr_i with
// wrap-around and returns the first hit as one-hot plus its index.
// Assumes ptr_i < N. Purely combinational.
module rr_pick #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic [PW-1:0] ptr_i,
    output logic [N-1:0]  gnt_o,
    output logic [PW-1:0] idx_o
);
    // Scan from the pointer and keep the first request found.
    always_comb begin
        logic found;
        found = 1'b0;
        gnt_o = '0;
        idx_o = '0;
        for (int off = 0; off < N; off++) begin
            int k;
            k = (int'(ptr_i) + off) % N;
            if (!found && req_i[k]) begin
                found    = 1'b1;
                gnt_o[k] = 1'b1;
                idx_o    = PW'(k);
            end
        end
    end
endmodule

// File: rtl/rrm_iter_stage.sv
// One request/grant/accept iteration across the whole crossbar.
// Requests from matched inputs or to matched outputs are masked.
// Each output grants once through its pointer, then each input accepts
// once through its pointer. Combinational; the caller registers the result.
module rrm_iter_stage #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*N-1:0]       req_i,
    input  logic [N-1:0]         in_busy_i,
    input  logic [N-1:0]         out_busy_i,
    input  logic [N-1:0][PW-1:0] gptr_i,
    input  logic [N-1:0][PW-1:0] aptr_i,
    output logic [N*N-1:0]       acc_o,
    output logic [N-1:0][PW-1:0] gidx_o,
    output logic [N-1:0][PW-1:0] aidx_o
);
    logic [N-1:0][N-1:0] col_req;   // [output][input]
    logic [N-1:0][N-1:0] gcol;      // grants, [output][input]
    logic [N-1:0][N-1:0] grow;      // grants seen by input, [input][output]
    logic [N-1:0][N-1:0] arow;      // accepts, [input][output]

    for (genvar j = 0; j < N; j++) begin : g_out
        for (genvar i = 0; i < N; i++) begin : g_in
            // Mask requests for ports already paired.
            assign col_req[j][i] = req_i[i*N+j] & ~in_busy_i[i] & ~out_busy_i[j];
            assign grow[i][j]    = gcol[j][i];
            assign acc_o[i*N+j]  = arow[i][j];
        end
        rr_pick #(.N(N), .PW(PW)) u_grant (
            .req_i (col_req[j]),
            .ptr_i (gptr_i[j]),
            .gnt_o (gcol[j]),
            .idx_o (gidx_o[j])
        );
    end

    for (genvar i = 0; i < N; i++) begin : g_acc
        rr_pick #(.N(N), .PW(PW)) u_accept (
            .req_i (grow[i]),
            .ptr_i (aptr_i[i]),
            .gnt_o (arow[i]),
            .idx_o (aidx_o[i])
        );
    end
endmodule

// File: rtl/rr_xbar_matcher.sv
// Iterative round-robin crossbar matcher (top).
// Captures the request bitmap on start, runs ITERS iterations of one cycle
// each, then publishes the matching with a one-cycle valid pulse.
// Pointers move only on pairs formed in the first iteration.
// Assumes 1 <= ITERS <= N. Synchronous active-low reset.
module rr_xbar_matcher #(
    parameter int N     = 4,
    parameter int ITERS = N
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N*N-1:0] req_i,
    output logic [N*N-1:0] match_o,
    output logic           valid_o
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(ITERS + 1);

    logic                 busy_q;
    logic [CW-1:0]        iter_q;
    logic [N*N-1:0]       req_q;
    logic [N*N-1:0]       work_q;
    logic [N*N-1:0]       match_q;
    logic                 valid_q;
    logic [N-1:0][PW-1:0] gptr_q;
    logic [N-1:0][PW-1:0] aptr_q;

    logic [N-1:0]         in_done;
    logic [N-1:0]         out_done;
    logic [N*N-1:0]       acc;
    logic [N-1:0]         acc_in;
    logic [N-1:0]         acc_out;
    logic [N-1:0][PW-1:0] gidx;
    logic [N-1:0][PW-1:0] aidx;
    logic                 first_it;
    logic                 last_it;

    // Row and column occupancy of the pairs built so far and of new accepts.
    always_comb begin
        in_done  = '0;
        out_done = '0;
        acc_in   = '0;
        acc_out  = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                in_done[i]  = in_done[i]  | work_q[i*N+j];
                out_done[j] = out_done[j] | work_q[i*N+j];
                acc_in[i]   = acc_in[i]   | acc[i*N+j];
                acc_out[j]  = acc_out[j]  | acc[i*N+j];
            end
        end
    end

    assign first_it = busy_q && (iter_q == '0);
    assign last_it  = busy_q && (iter_q == CW'(ITERS - 1));

    rrm_iter_stage #(.N(N), .PW(PW)) u_stage (
        .req_i      (req_q),
        .in_busy_i  (in_done),
        .out_busy_i (out_done),
        .gptr_i     (gptr_q),
        .aptr_i     (aptr_q),
        .acc_o      (acc),
        .gidx_o     (gidx),
        .aidx_o     (aidx)
    );

    // Run control: capture on start, accumulate pairs, publish at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            iter_q  <= '0;
            req_q   <= '0;
            work_q  <= '0;
            match_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (!busy_q && start_i) begin
                busy_q <= 1'b1;
                iter_q <= '0;
                req_q  <= req_i;
                work_q <= '0;
            end else if (busy_q) begin
                work_q <= work_q | acc;
                if (last_it) begin
                    busy_q  <= 1'b0;
                    match_q <= work_q | acc;
                    valid_q <= 1'b1;
                end else begin
                    iter_q <= iter_q + 1'b1;
                end
            end
        end
    end

    // Pointer update: only pairs accepted in the first iteration move them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gptr_q <= '0;
            aptr_q <= '0;
        end else if (first_it) begin
            for (int k = 0; k < N; k++) begin
                if (acc_out[k]) gptr_q[k] <= PW'(rrm_pkg::next_port(int'(gidx[k]), N));
                if (acc_in[k])  aptr_q[k] <= PW'(rrm_pkg::next_port(int'(aidx[k]), N));
            end
        end
    end

    assign match_o = match_q;
    assign valid_o = valid_q;

    // ---------------- assertions ----------------
    logic [N-1:0] res_row;
    logic [N-1:0] res_col;
    logic         leftover;

    // Occupancy of the published result and any request left unserved.
    always_comb begin
        res_row  = '0;
        res_col  = '0;
        leftover = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                res_row[i] = res_row[i] | match_q[i*N+j];
                res_col[j] = res_col[j] | match_q[i*N+j];
            end
        end
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (req_q[i*N+j] && !res_row[i] && !res_col[j]) leftover = 1'b1;
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        logic [N-1:0] colv;
        for (genvar r = 0; r < N; r++) begin : g_col
            assign colv[r] = match_q[r*N+i];
        end
        AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(match_q[i*N +: N])); // R4
        AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(colv)); // R4
    end

    AST_MATCH_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ((match_q & ~req_q) == '0)); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q); // R3
    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_it |=> valid_q); // R3
    AST_MAXIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && ITERS == N) |-> !leftover); // R5
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !first_it |=> ($stable(gptr_q) && $stable(aptr_q))); // R8
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i) |=> $stable(req_q)); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !last_it |=> $stable(match_q)); // R11
endmodule

// File: tb/test_rr_xbar_matcher.sv
`timescale 1ns/1ps
module test_rr_xbar_matcher;
    localparam int N     = 4;
    localparam int ITERS = N;
    localparam int NN    = N * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [NN-1:0] req_i = '0;
    logic [NN-1:0] match_o;
    logic          valid_o;

    int checks = 0;
    int errors = 0;
    int gp [N];
    int ap [N];
    logic [NN-1:0] last_res = '0;

    always #10 clk = ~clk;

    rr_xbar_matcher #(.N(N), .ITERS(ITERS)) i_rr_xbar_matcher (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .req_i(req_i), .match_o(match_o), .valid_o(valid_o)
    );

    task automatic check(input bit ok, input string tag, input logic [NN-1:0] act, input logic [NN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected result from the scheduling rules; updates the model pointers.
    task automatic model(input logic [NN-1:0] r, output logic [NN-1:0] res);
        bit mi [N];
        bit mo [N];
        int g [N];
        res = '0;
        for (int k = 0; k < N; k++) begin mi[k] = 0; mo[k] = 0; end
        for (int it = 0; it < ITERS; it++) begin
            for (int j = 0; j < N; j++) begin
                g[j] = -1;
                if (!mo[j])
                    for (int off = 0; off < N; off++) begin
                        int i = (gp[j] + off) % N;
                        if (g[j] < 0 && r[i*N+j] && !mi[i]) g[j] = i;
                    end
            end
            for (int i = 0; i < N; i++) begin
                int pick = -1;
                if (!mi[i])
                    for (int off = 0; off < N; off++) begin
                        int j = (ap[i] + off) % N;
                        if (pick < 0 && g[j] == i) pick = j;
                    end
                if (pick >= 0) begin
                    mi[i] = 1; mo[pick] = 1;
                    res[i*N+pick] = 1'b1;
                    if (it == 0) begin
                        ap[i]    = (pick + 1) % N;
                        gp[pick] = (i + 1) % N;
                    end
                end
            end
        end
    endtask

    function automatic bit legal(input logic [NN-1:0] m, input logic [NN-1:0] r);
        for (int i = 0; i < N; i++) begin
            int rc = 0;
            int cc = 0;
            for (int j = 0; j < N; j++) begin
                rc += int'(m[i*N+j]);
                cc += int'(m[j*N+i]);
            end
            if (rc > 1 || cc > 1) return 0;
        end
        return (m & ~r) == '0;
    endfunction

    function automatic bit maximal(input logic [NN-1:0] m, input logic [NN-1:0] r);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (r[i*N+j] && (m[i*N +: N] == '0)) begin
                    bit used = 0;
                    for (int k = 0; k < N; k++) used |= m[k*N+j];
                    if (!used) return 0;
                end
        return 1;
    endfunction

    // One run. The start is driven at the current negedge; when the previous
    // run has just finished, this falls in its valid cycle (R10).
    // A nonzero 'disturb' also drives a start while busy (R9).
    task automatic run(input logic [NN-1:0] r, input bit disturb);
        logic [NN-1:0] exp;
        int pulses = 0;
        model(r, exp);
        start_i = 1'b1;
        req_i   = r;
        @(posedge clk);
        @(negedge clk);
        start_i = disturb;
        req_i   = ~r;
        for (int k = 1; k <= ITERS; k++) begin
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            req_i   = NN'($urandom);   // R2: changes after capture have no effect
            if (valid_o) pulses++;
            if (k < ITERS) check(!valid_o, "R3 early valid", NN'(valid_o), '0);
        end
        check(valid_o && pulses == 1, "R3 valid timing", NN'(pulses), NN'(1));
        check(match_o == exp, disturb ? "R9/R2 result" : "R6/R7/R8/R10 result", match_o, exp);
        check(legal(match_o, r), "R4 legal", match_o, exp);
        check(maximal(match_o, r), "R5 maximal", match_o, exp);
        last_res = match_o;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < N; k++) begin gp[k] = 0; ap[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!valid_o && match_o == '0, "R1 reset state", match_o, '0);
        // R1: pointers at zero, so a full bitmap yields the diagonal
        run({NN{1'b1}}, 1'b0);
        check(match_o == NN'(16'h8421), "R1 first full run", match_o, NN'(16'h8421));
        run('0, 1'b0);                               // empty request
        run({NN{1'b1}}, 1'b0);                       // rotated pointers
        run(NN'(16'h000F), 1'b0);                    // one input wants all
        run(NN'(16'h1111), 1'b0);                    // all want output 0
        run(NN'(16'hA5A5), 1'b1);                    // R9 start while busy
        // R11: result holds while idle
        repeat (5) begin
            @(negedge clk);
            check(!valid_o && match_o == last_res, "R11 hold", match_o, last_res);
        end
        for (int n = 0; n < 300; n++) begin
            logic [NN-1:0] r = NN'($urandom);
            if (n % 3 == 0) r = r & NN'($urandom);
            if (n % 5 == 0) r = r | NN'($urandom);
            run(r, (n % 7) == 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule